// File: doc/BRIEF.md
# Guarded Return Address Stack

This block keeps a hardware-owned shadow copy of return addresses for a processor front end. Each call-with-link pushes its return address. Each procedure return removes the newest entry. In compare mode, the removed entry is checked against the link register value. In direct mode, the removed entry becomes the return target itself.

Software has two dedicated commands, a push and a pop, for stack upkeep such as unwinding a long jump. Any other store aimed at the stack is refused. A read port returns the entry at a chosen distance below the top without moving the pointer. A profiler can use it to copy the whole call chain.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY` moves to `OCC_PARTIAL` on a push, or to `OCC_FULL` when the depth is 1.
- `OCC_PARTIAL` moves to `OCC_EMPTY` when the count reaches zero, and to `OCC_FULL` when the count reaches capacity.
- `OCC_FULL` moves to `OCC_PARTIAL` on a pop.

All command results appear as one-cycle pulses in the cycle after the command.

Top module: `shadow_ret_stack`

## Requirements
- R1: After reset, depth_count is 0, stack_empty is 1, stack_full is 0, and every result pulse is low.
- R2: A call with call_valid stores call_addr as the newest entry. depth_count rises by one in the next cycle.
- R3: A return with ret_valid on a non-empty stack removes the newest entry and pulses ret_done in the next cycle. With mode_direct=1, ret_target equals the removed value.
- R4: With mode_direct=0, ret_target equals link_value. ret_mismatch pulses for one cycle when the removed value differs from link_value, and the entry is removed anyway.
- R5: A push (call or software) when depth_count is 32 pulses overflow. The stored contents and the depth stay unchanged.
- R6: A pop (return or software) on an empty stack pulses underflow with no ret_done. The depth stays at 0.
- R7: When a call and a return arrive in the same cycle, the return is processed first and then the call. On a full stack this replaces the top entry without overflow.
- R8: sw_push_valid stores sw_push_addr as the newest entry. sw_pop_valid discards the newest entry without ret_done. If both are set, only the push takes effect.
- R9: Software push and pop commands have no effect in a cycle where call_valid or ret_valid is set.
- R10: store_attempt pulses store_reject in the next cycle and changes neither the contents nor the depth.
- R11: peek_hit is 1 and peek_data is the entry peek_depth places below the top (0 = newest) when peek_depth < depth_count. Otherwise peek_hit is 0 and peek_data is 0. The read is combinational and moves no pointer.
- R12: stack_empty and stack_full follow the occupancy state machine and agree with depth_count (0 and 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | 1: removed value is the return target; 0: compare against link value |
| call_valid | input | 1 | Call-with-link occurred |
| call_addr | input | 64 | Return address of the call |
| ret_valid | input | 1 | Procedure return occurred |
| link_value | input | 64 | Current link register value |
| sw_push_valid | input | 1 | Software push command |
| sw_push_addr | input | 64 | Value for the software push |
| sw_pop_valid | input | 1 | Software pop command |
| store_attempt | input | 1 | Ordinary store aimed at the stack (refused) |
| peek_depth | input | 5 | Distance below the top for the read port |
| peek_hit | output | 1 | Read port addresses a live entry |
| peek_data | output | 64 | Entry at peek_depth, or 0 |
| ret_done | output | 1 | A return removed an entry |
| ret_target | output | 64 | Return target (0 when ret_done is low) |
| ret_mismatch | output | 1 | Compare-mode mismatch pulse |
| overflow | output | 1 | Push refused, stack full |
| underflow | output | 1 | Pop refused, stack empty |
| store_reject | output | 1 | Ordinary store refused |
| depth_count | output | 6 | Number of live entries |
| stack_empty | output | 1 | Occupancy state is empty |
| stack_full | output | 1 | Occupancy state is full |

## Verification
A corrupted pointer shows up at the ports in the very next cycle. depth_count drifts from the model, and the read port returns data from the wrong depth or the wrong hit flag. A wrong entry stays hidden until it is either peeked or popped. For that reason the read port sweeps random depths every cycle, which exposes a bad slot within a few cycles instead of only at the matching return. An occupancy state that has fallen out of step with the counter is visible at once on stack_empty and stack_full. A lost ordering between a same-cycle return and call shows as a wrong top value or a spurious overflow.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/srs_store.sv
module srs_store #(
    parameter int DEPTH = 32,
    parameter int AW    = 64,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [PW-1:0] top_addr,
    output logic [AW-1:0] top_data,
    input  logic [PW-1:0] peek_addr,
    output logic [AW-1:0] peek_rd
);
    logic [AW-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign top_data = slots[top_addr];
    assign peek_rd  = slots[peek_addr];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
    import srs_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_v,
    input  logic          ret_v,
    input  logic          swpush_v,
    input  logic          swpop_v,
    output logic [CW-1:0] cnt,
    output occ_e          occ,
    output logic          ret_pop,
    output logic          ret_unf,
    output logic          call_push,
    output logic          call_ovf,
    output logic          sw_push,
    output logic          sw_ovf,
    output logic          sw_unf,
    output logic          we,
    output logic [PW-1:0] waddr
);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic          hw_busy, sw_pop;
    logic [CW-1:0] cnt_after_ret, cnt_nxt;
    occ_e          occ_nxt;

    always_comb begin
        hw_busy       = call_v | ret_v;
        ret_pop       = ret_v && (cnt != '0);
        ret_unf       = ret_v && (cnt == '0);
        cnt_after_ret = ret_pop ? cnt - CW'(1) : cnt;
        call_push     = call_v && (cnt_after_ret != FULLC);
        call_ovf      = call_v && (cnt_after_ret == FULLC);
        sw_push       = !hw_busy && swpush_v && (cnt != FULLC);
        sw_ovf        = !hw_busy && swpush_v && (cnt == FULLC);
        sw_pop        = !hw_busy && !swpush_v && swpop_v && (cnt != '0);
        sw_unf        = !hw_busy && !swpush_v && swpop_v && (cnt == '0);
        we            = call_push | sw_push;
        waddr         = PW'(cnt_after_ret);
        cnt_nxt       = cnt_after_ret + CW'(call_push) + CW'(sw_push) - CW'(sw_pop);
    end

    always_comb begin
        occ_nxt = occ;
        unique case (occ)
            OCC_EMPTY: begin
                if (cnt_nxt == FULLC)    occ_nxt = OCC_FULL;
                else if (cnt_nxt != '0)  occ_nxt = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (cnt_nxt == '0)         occ_nxt = OCC_EMPTY;
                else if (cnt_nxt == FULLC) occ_nxt = OCC_FULL;
            end
            OCC_FULL: begin
                if (cnt_nxt == '0)         occ_nxt = OCC_EMPTY;
                else if (cnt_nxt != FULLC) occ_nxt = OCC_PARTIAL;
            end
            default: occ_nxt = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= OCC_EMPTY;
            cnt <= '0;
        end else begin
            occ <= occ_nxt;
            cnt <= cnt_nxt;
        end
    end

    // R12: the occupancy state agrees with the counter
    a_r12_empty_state: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_EMPTY) |-> (cnt == '0));
    a_r12_full_state: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_FULL) |-> (cnt == FULLC));
    // R5: the count never passes capacity, and a refused call leaves it untouched
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULLC);
    a_r5_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        call_ovf |=> $stable(cnt));
    // R6: a return on an empty stack with no call leaves the count at zero
    a_r6_unf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_unf && !call_v) |=> (cnt == '0));
    // R7: a return and a call together on a non-empty stack keep the depth
    a_r7_ret_then_call: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_v && call_v && cnt != '0) |=> $stable(cnt));
endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack
    import srs_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_direct,
    input  logic          call_valid,
    input  logic [AW-1:0] call_addr,
    input  logic          ret_valid,
    input  logic [AW-1:0] link_value,
    input  logic          sw_push_valid,
    input  logic [AW-1:0] sw_push_addr,
    input  logic          sw_pop_valid,
    input  logic          store_attempt,
    input  logic [PW-1:0] peek_depth,
    output logic          peek_hit,
    output logic [AW-1:0] peek_data,
    output logic          ret_done,
    output logic [AW-1:0] ret_target,
    output logic          ret_mismatch,
    output logic          overflow,
    output logic          underflow,
    output logic          store_reject,
    output logic [CW-1:0] depth_count,
    output logic          stack_empty,
    output logic          stack_full
);
    logic [CW-1:0] cnt;
    occ_e          occ;
    logic          ret_pop, ret_unf, call_push, call_ovf, sw_push, sw_ovf, sw_unf, we;
    logic [PW-1:0] waddr, top_addr, peek_addr;
    logic [AW-1:0] wdata, top_data, peek_rd;

    srs_ctrl #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .call_v(call_valid), .ret_v(ret_valid),
        .swpush_v(sw_push_valid), .swpop_v(sw_pop_valid),
        .cnt(cnt), .occ(occ),
        .ret_pop(ret_pop), .ret_unf(ret_unf),
        .call_push(call_push), .call_ovf(call_ovf),
        .sw_push(sw_push), .sw_ovf(sw_ovf), .sw_unf(sw_unf),
        .we(we), .waddr(waddr)
    );

    assign wdata     = call_push ? call_addr : sw_push_addr;
    assign top_addr  = PW'(cnt - CW'(1));
    assign peek_addr = PW'(cnt - CW'(1) - CW'(peek_depth));

    srs_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .top_addr(top_addr), .top_data(top_data),
        .peek_addr(peek_addr), .peek_rd(peek_rd)
    );

    assign peek_hit    = CW'(peek_depth) < cnt;
    assign peek_data   = peek_hit ? peek_rd : '0;
    assign depth_count = cnt;
    assign stack_empty = (occ == OCC_EMPTY);
    assign stack_full  = (occ == OCC_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_done     <= 1'b0;
            ret_target   <= '0;
            ret_mismatch <= 1'b0;
            overflow     <= 1'b0;
            underflow    <= 1'b0;
            store_reject <= 1'b0;
        end else begin
            ret_done     <= ret_pop;
            ret_target   <= ret_pop ? (mode_direct ? top_data : link_value) : '0;
            ret_mismatch <= ret_pop && !mode_direct && (top_data != link_value);
            overflow     <= call_ovf | sw_ovf;
            underflow    <= ret_unf | sw_unf;
            store_reject <= store_attempt;
        end
    end

    // R4: a mismatch pulse only follows a compare-mode return
    a_r4_mismatch_compare: assert property (@(posedge clk) disable iff (!rst_n)
        ret_mismatch |-> (ret_done && !$past(mode_direct)));
    // R6: an underflow never coincides with a completed return
    a_r6_unf_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !ret_done);
    // R10: a rejected store follows a store attempt
    a_r10_reject_source: assert property (@(posedge clk) disable iff (!rst_n)
        store_reject |-> $past(store_attempt));
    // R11: the read port never hits on an empty stack
    a_r11_peek_empty: assert property (@(posedge clk) disable iff (!rst_n)
        stack_empty |-> !peek_hit);
endmodule

// File: tb/shadow_ret_stack_tb_top.sv
module shadow_ret_stack_tb_top;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_direct = 1'b1;
    logic        call_valid = 1'b0, ret_valid = 1'b0;
    logic        sw_push_valid = 1'b0, sw_pop_valid = 1'b0, store_attempt = 1'b0;
    logic [63:0] call_addr = '0, link_value = '0, sw_push_addr = '0;
    logic [4:0]  peek_depth = '0;
    logic        peek_hit, ret_done, ret_mismatch, overflow, underflow, store_reject;
    logic        stack_empty, stack_full;
    logic [63:0] peek_data, ret_target;
    logic [5:0]  depth_count;

    always #2.5 clk = ~clk;

    shadow_ret_stack dut_i (
        .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct),
        .call_valid(call_valid), .call_addr(call_addr),
        .ret_valid(ret_valid), .link_value(link_value),
        .sw_push_valid(sw_push_valid), .sw_push_addr(sw_push_addr),
        .sw_pop_valid(sw_pop_valid), .store_attempt(store_attempt),
        .peek_depth(peek_depth), .peek_hit(peek_hit), .peek_data(peek_data),
        .ret_done(ret_done), .ret_target(ret_target), .ret_mismatch(ret_mismatch),
        .overflow(overflow), .underflow(underflow), .store_reject(store_reject),
        .depth_count(depth_count), .stack_empty(stack_empty), .stack_full(stack_full)
    );

    int n_chk = 0, n_fail = 0;
    bit started = 0, finished = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [63:0] q[$];
    logic        e_done, e_mis, e_ovf, e_unf, e_rej;
    logic [63:0] e_tgt;

    always @(posedge clk) begin
        started <= 1'b1;
        e_done = 0; e_mis = 0; e_ovf = 0; e_unf = 0; e_rej = 0; e_tgt = '0;
        if (!rst_n) begin
            q.delete();
        end else begin
            if (ret_valid) begin
                if (q.size() == 0) e_unf = 1;
                else begin
                    logic [63:0] v;
                    v = q.pop_back();
                    e_done = 1;
                    e_tgt = mode_direct ? v : link_value;
                    e_mis = !mode_direct && (v != link_value);
                end
            end
            if (call_valid) begin
                if (q.size() == DEPTH) e_ovf = 1;
                else q.push_back(call_addr);
            end
            if (!call_valid && !ret_valid) begin
                if (sw_push_valid) begin
                    if (q.size() == DEPTH) e_ovf = 1;
                    else q.push_back(sw_push_addr);
                end else if (sw_pop_valid) begin
                    if (q.size() == 0) e_unf = 1;
                    else void'(q.pop_back());
                end
            end
            e_rej = store_attempt;
        end
    end

    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            int d;
            logic [63:0] pe;
            chk("R2 depth_count", 64'(depth_count), 64'(q.size()));
            chk("R3 ret_done", 64'(ret_done), 64'(e_done));
            chk("R3/R4 ret_target", ret_target, e_tgt);
            chk("R4 ret_mismatch", 64'(ret_mismatch), 64'(e_mis));
            chk("R5 overflow", 64'(overflow), 64'(e_ovf));
            chk("R6 underflow", 64'(underflow), 64'(e_unf));
            chk("R10 store_reject", 64'(store_reject), 64'(e_rej));
            d = int'(peek_depth);
            pe = (d < q.size()) ? q[q.size() - 1 - d] : 64'h0;
            chk("R11 peek_hit", 64'(peek_hit), 64'(d < q.size()));
            chk("R11 peek_data", peek_data, pe);
            chk("R12 stack_empty", 64'(stack_empty), 64'(q.size() == 0));
            chk("R12 stack_full", 64'(stack_full), 64'(q.size() == DEPTH));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        call_valid = 0; ret_valid = 0; sw_push_valid = 0; sw_pop_valid = 0; store_attempt = 0;
    endtask

    task automatic do_call(input logic [63:0] a);
        call_valid = 1; call_addr = a; tick();
    endtask

    task automatic do_ret(input logic [63:0] lv);
        ret_valid = 1; link_value = lv; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset depth", 64'(depth_count), 64'd0);
        chk("R1 reset empty", 64'(stack_empty), 64'd1);
        chk("R1 reset pulses", 64'({ret_done, ret_mismatch, overflow, underflow, store_reject, stack_full}), 64'd0);
        rst_n = 1;
        tick();

        // R2, R3 direct mode
        do_call(64'hA0); do_call(64'hA1); do_call(64'hA2);
        chk("R2 three calls", 64'(depth_count), 64'd3);
        mode_direct = 1; do_ret(64'h0);
        chk("R3 direct target", ret_target, 64'hA2);
        // R4 compare mode, mismatch still pops
        mode_direct = 0; do_ret(64'hBAD);
        chk("R4 mismatch pulse", 64'(ret_mismatch), 64'd1);
        chk("R4 entry removed", 64'(depth_count), 64'd1);
        do_ret(64'hA0);
        chk("R4 match no pulse", 64'(ret_mismatch), 64'd0);
        // R6 empty pops
        do_ret(64'h0);
        chk("R6 ret underflow", 64'(underflow), 64'd1);
        sw_pop_valid = 1; tick();
        chk("R6 sw underflow", 64'(underflow), 64'd1);
        // R5 fill and overflow
        for (int i = 0; i < DEPTH; i++) do_call(64'h1000 + 64'(i));
        chk("R12 full", 64'(stack_full), 64'd1);
        do_call(64'hDEAD);
        chk("R5 call overflow", 64'(overflow), 64'd1);
        peek_depth = 0; #1;
        chk("R5 top unchanged", peek_data, 64'h101F);
        sw_push_valid = 1; sw_push_addr = 64'hBEEF; tick();
        chk("R5 sw overflow", 64'(overflow), 64'd1);
        // R7 return and call together on full stack
        mode_direct = 1; call_valid = 1; call_addr = 64'hC0DE; ret_valid = 1; tick();
        chk("R7 no overflow", 64'(overflow), 64'd0);
        chk("R7 target old top", ret_target, 64'h101F);
        chk("R7 top replaced", peek_data, 64'hC0DE);
        chk("R7 depth kept", 64'(depth_count), 64'd32);
        // R11 peek deep
        peek_depth = 31; #1;
        chk("R11 bottom entry", peek_data, 64'h1000);
        // R8 sw pop and push priority
        sw_pop_valid = 1; tick();
        chk("R8 sw pop no ret_done", 64'(ret_done), 64'd0);
        chk("R8 sw pop depth", 64'(depth_count), 64'd31);
        sw_push_valid = 1; sw_pop_valid = 1; sw_push_addr = 64'h5A5A; tick();
        peek_depth = 0; #1;
        chk("R8 push wins", peek_data, 64'h5A5A);
        // R9 sw ignored while call active
        call_valid = 1; call_addr = 64'h7777; sw_pop_valid = 1; tick();
        chk("R9 sw pop ignored", 64'(depth_count), 64'd32);
        ret_valid = 1; sw_push_valid = 1; sw_push_addr = 64'h9999; tick();
        chk("R9 sw push ignored", 64'(depth_count), 64'd31);
        // R10 store attempt
        store_attempt = 1; tick();
        chk("R10 reject pulse", 64'(store_reject), 64'd1);
        chk("R10 depth kept", 64'(depth_count), 64'd31);
        // drain, then R7 on empty
        while (depth_count != 0) do_ret(64'h0);
        call_valid = 1; call_addr = 64'hE1; ret_valid = 1; tick();
        chk("R7 empty underflow", 64'(underflow), 64'd1);
        chk("R7 empty then push", 64'(depth_count), 64'd1);

        // Random traffic, call-heavy then return-heavy phases
        for (int ph = 0; ph < 8; ph++) begin
            for (int c = 0; c < 500; c++) begin
                int cw = (ph % 2 == 0) ? 2 : 5;
                int rw = (ph % 2 == 0) ? 5 : 2;
                call_valid    = ($urandom % cw) == 0;
                ret_valid     = ($urandom % rw) == 0;
                sw_push_valid = ($urandom % 8) == 0;
                sw_pop_valid  = ($urandom % 8) == 0;
                store_attempt = ($urandom % 10) == 0;
                if ($urandom % 40 == 0) mode_direct = ~mode_direct;
                call_addr     = {$urandom, $urandom};
                sw_push_addr  = {$urandom, $urandom};
                link_value    = (q.size() > 0 && $urandom % 2) ? q[$] : {$urandom, $urandom};
                peek_depth    = 5'($urandom % 32);
                tick();
            end
        end
        repeat (2) tick();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule